// File: doc/BRIEF.md
# Pseudo-Associative Cache Controller

This block is a data cache built on one direct-mapped array of word-sized lines whose sets are paired. Two sets form a pair when their indexes differ only in the top bit. A CPU access first looks in its natural (home) slot. If the line is not there, the controller looks in the partner slot of the pair in the following cycle. A match in the partner slot is a slow hit. A miss in both slots goes to memory. The result is three latencies: a fast hit, a slow hit and a full miss. The cost is about the same as a direct-mapped array, and the pairing removes many of the conflicts between two addresses that share an index.

Each stored line carries a marker that records which half of the array holds its home slot. A line sitting in its partner slot therefore cannot be taken for a different address that has the same tag. After a slow hit, the two lines of the pair change places, so a repeated access becomes fast. On a full miss, the fetched line takes the home slot and the line that was there moves into the partner slot. The line pushed out of the partner slot is written back to memory first if it was modified. Writes are write-back and write-allocate.

The CPU side is a request/ready port carrying a word address. It returns one response per access, with the data and a hit-type code. The memory side is a single request line that is held until an acknowledge pulse. The same request line serves both line write-backs and line fills.

Top module: `pac_cache`

## Requirements
- R1: After reset every slot is invalid: `cpu_ready` is 1, `rsp_valid` and `mem_req` are 0, and the first access to any address completes as a miss.
- R2: An access whose line is in its home slot (index = address bits [IDX_W-1:0]) gets `rsp_valid` one cycle after acceptance, with `rsp_kind` = 2'b01 (fast). `rsp_kind` is 2'b00 whenever `rsp_valid` is 0.
- R3: If the home slot misses, the partner slot is probed. The partner index is the home index with its most significant bit inverted. A match there gives `rsp_valid` two cycles after acceptance, with `rsp_kind` = 2'b10 (slow) and no memory traffic.
- R4: After a slow hit the two lines of the pair are swapped. The next access to the same address is fast, and the line that was in the home slot now answers as a slow hit.
- R5: A miss in both slots issues a memory read (`mem_we` = 0) for the requested word address. `rsp_valid` rises the cycle after `mem_ack`, with `rsp_kind` = 2'b11 (miss) and, for a read, the data from `mem_rdata`.
- R6: On a full miss, the line in the home slot moves to the partner slot and stays reachable as a slow hit. The line previously in the partner slot leaves the cache, and its next access misses.
- R7: A modified line leaving the cache is written to memory (`mem_we` = 1, its own address and data) before the fill read. A clean line leaving the cache causes no memory write. `mem_addr` and `mem_we` are held until `mem_ack`.
- R8: Writes store `cpu_wdata` and return it on `rsp_rdata`. Later reads return the latest written value. A write miss allocates the line as modified and does not write memory.
- R9: Only one access is in flight. `cpu_ready` is 0 from the cycle after a non-fast acceptance until its response, and is always 0 while `mem_req` is 1.
- R10: Two addresses with equal tags whose indexes differ only in the top bit are distinct lines: a line in one's partner slot never hits for the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request accepted when high with cpu_req |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_kind | output | 2 | 01 fast, 10 slow, 11 miss, 00 idle |
| rsp_rdata | output | DATA_W | Read data, or the written data for writes |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = write-back, 0 = line fill |
| mem_addr | output | ADDR_W | Word address of the line |
| mem_wdata | output | DATA_W | Write-back data |
| mem_ack | input | 1 | Memory completion pulse |
| mem_rdata | input | DATA_W | Fill data, valid with mem_ack |

## Verification
The hardest case to reach from the ports is a modified line being evicted from the partner slot. That line must first be written, then pushed out of its home slot by a miss, then pulled back by a slow hit, and finally displaced again by a third address that shares the index. The stimulus builds this chain on one pair of sets and then reads the evicted address back, so the written-back value has to come from memory. A same-tag address in the other half of the pair is also accessed while its twin sits in the partner slot, which shows that the half marker prevents a false hit.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [1:0] {
    HK_NONE = 2'b00,
    HK_FAST = 2'b01,
    HK_SLOW = 2'b10,
    HK_MISS = 2'b11
  } hit_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PROBE2,
    ST_WBACK,
    ST_FILL
  } pac_state_e;
endpackage

// File: rtl/pac_array.sv
// Line storage: per-set valid/dirty bits with reset, body without reset.
// Entry layout: {valid, dirty, half, tag, data}.
module pac_array #(
  parameter int IDX_W = 4,
  parameter int EW    = 45
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd0_idx,
  output logic [EW-1:0]    rd0_ent,
  input  logic [IDX_W-1:0] rd1_idx,
  output logic [EW-1:0]    rd1_ent,
  input  logic             wr0_en,
  input  logic [IDX_W-1:0] wr0_idx,
  input  logic [EW-1:0]    wr0_ent,
  input  logic             wr1_en,
  input  logic [IDX_W-1:0] wr1_idx,
  input  logic [EW-1:0]    wr1_ent
);
  localparam int SETS = 1 << IDX_W;
  localparam int BW   = EW - 2;

  logic [1:0]    meta_all [SETS];
  logic [BW-1:0] body_q   [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [1:0] meta_q;
    logic       hit0, hit1;
    assign hit0 = wr0_en && (wr0_idx == IDX_W'(s));
    assign hit1 = wr1_en && (wr1_idx == IDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    meta_q <= 2'b00;
      else if (hit0) meta_q <= wr0_ent[EW-1:EW-2];
      else if (hit1) meta_q <= wr1_ent[EW-1:EW-2];
    end
    assign meta_all[s] = meta_q;
  end

  always_ff @(posedge clk) begin
    if (wr0_en) body_q[wr0_idx] <= wr0_ent[BW-1:0];
    if (wr1_en) body_q[wr1_idx] <= wr1_ent[BW-1:0];
  end

  assign rd0_ent = {meta_all[rd0_idx], body_q[rd0_idx]};
  assign rd1_ent = {meta_all[rd1_idx], body_q[rd1_idx]};
endmodule

// File: rtl/pac_probe.sv
// Tag compare for one slot: valid, same tag and same home half.
module pac_probe #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  parameter int EW     = 3 + TAG_W + DATA_W
) (
  input  logic [EW-1:0]    ent,
  input  logic [TAG_W-1:0] want_tag,
  input  logic             want_half,
  output logic             hit
);
  logic             v;
  logic             h;
  logic [TAG_W-1:0] t;
  assign v   = ent[EW-1];
  assign h   = ent[EW-3];
  assign t   = ent[DATA_W +: TAG_W];
  assign hit = v && (h == want_half) && (t == want_tag);
endmodule

// File: rtl/pac_ctrl.sv
// Access sequencer: home probe, partner probe, write-back, fill.
module pac_ctrl
  import pac_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = ADDR_W - IDX_W,
  parameter int EW     = 3 + TAG_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  home_idx,
  output logic [IDX_W-1:0]  alt_idx,
  output logic [TAG_W-1:0]  want_tag,
  output logic              want_half,
  input  logic [EW-1:0]     home_ent,
  input  logic [EW-1:0]     alt_ent,
  input  logic              home_hit,
  input  logic              alt_hit,
  output logic              wr0_en,
  output logic [IDX_W-1:0]  wr0_idx,
  output logic [EW-1:0]     wr0_ent,
  output logic              wr1_en,
  output logic [IDX_W-1:0]  wr1_idx,
  output logic [EW-1:0]     wr1_ent
);
  localparam int LO_W = IDX_W - 1;

  pac_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              cap_en;
  logic              rsp_v_q, rsp_v_d;
  hit_kind_e         rsp_k_q, rsp_k_d;
  logic [DATA_W-1:0] rsp_d_q, rsp_d_d;
  logic [ADDR_W-1:0] sel_addr;
  logic [EW-1:0]     merged;

  function automatic logic [EW-1:0] mk_ent(input logic dirty, input logic half,
                                           input logic [TAG_W-1:0] tag,
                                           input logic [DATA_W-1:0] dat);
    return {1'b1, dirty, half, tag, dat};
  endfunction

  // Address under lookup: live CPU address when idle, captured one otherwise
  assign sel_addr  = (state_q == ST_IDLE) ? cpu_addr : addr_q;
  assign home_idx  = sel_addr[IDX_W-1:0];
  assign alt_idx   = {~home_idx[IDX_W-1], home_idx[LO_W-1:0]};
  assign want_tag  = sel_addr[ADDR_W-1:IDX_W];
  assign want_half = home_idx[IDX_W-1];

  assign cpu_ready = (state_q == ST_IDLE);

  // Partner line with a pending write folded in
  assign merged = we_q ? mk_ent(1'b1, want_half, want_tag, wdata_q) : alt_ent;

  always_comb begin
    state_d   = state_q;
    cap_en    = 1'b0;
    rsp_v_d   = 1'b0;
    rsp_k_d   = HK_NONE;
    rsp_d_d   = '0;
    wr0_en    = 1'b0;
    wr0_idx   = home_idx;
    wr0_ent   = '0;
    wr1_en    = 1'b0;
    wr1_idx   = alt_idx;
    wr1_ent   = home_ent;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = alt_ent[DATA_W-1:0];
    case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          cap_en = 1'b1;
          if (home_hit) begin
            rsp_v_d = 1'b1;
            rsp_k_d = HK_FAST;
            rsp_d_d = cpu_we ? cpu_wdata : home_ent[DATA_W-1:0];
            wr0_en  = cpu_we;
            wr0_ent = mk_ent(1'b1, want_half, want_tag, cpu_wdata);
          end else begin
            state_d = ST_PROBE2;
          end
        end
      end
      ST_PROBE2: begin
        if (alt_hit) begin
          wr0_en  = 1'b1;
          wr0_ent = merged;
          wr1_en  = 1'b1;
          rsp_v_d = 1'b1;
          rsp_k_d = HK_SLOW;
          rsp_d_d = merged[DATA_W-1:0];
          state_d = ST_IDLE;
        end else if (alt_ent[EW-1] && alt_ent[EW-2]) begin
          state_d = ST_WBACK;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_WBACK: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {alt_ent[DATA_W +: TAG_W], alt_ent[EW-3], home_idx[LO_W-1:0]};
        if (mem_ack) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          wr0_en  = 1'b1;
          wr0_ent = mk_ent(we_q, want_half, want_tag, we_q ? wdata_q : mem_rdata);
          wr1_en  = 1'b1;
          rsp_v_d = 1'b1;
          rsp_k_d = HK_MISS;
          rsp_d_d = we_q ? wdata_q : mem_rdata;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rsp_v_q <= 1'b0;
      rsp_k_q <= HK_NONE;
      rsp_d_q <= '0;
    end else begin
      state_q <= state_d;
      rsp_v_q <= rsp_v_d;
      rsp_k_q <= rsp_k_d;
      rsp_d_q <= rsp_d_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= cpu_addr;
      we_q    <= cpu_we;
      wdata_q <= cpu_wdata;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_kind  = rsp_k_q;
  assign rsp_rdata = rsp_d_q;
endmodule

// File: rtl/pac_cache.sv
module pac_cache #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int EW    = 3 + TAG_W + DATA_W;

  logic [IDX_W-1:0] home_idx, alt_idx, wr0_idx, wr1_idx;
  logic [TAG_W-1:0] want_tag;
  logic             want_half;
  logic [EW-1:0]    ent [2];
  logic [1:0]       hit;
  logic             wr0_en, wr1_en;
  logic [EW-1:0]    wr0_ent, wr1_ent;

  pac_array #(.IDX_W(IDX_W), .EW(EW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd0_idx(home_idx), .rd0_ent(ent[0]),
    .rd1_idx(alt_idx),  .rd1_ent(ent[1]),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_ent(wr0_ent),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_ent(wr1_ent)
  );

  for (genvar p = 0; p < 2; p++) begin : g_probe
    pac_probe #(.TAG_W(TAG_W), .DATA_W(DATA_W), .EW(EW)) u_probe (
      .ent(ent[p]), .want_tag(want_tag), .want_half(want_half), .hit(hit[p])
    );
  end

  pac_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
             .TAG_W(TAG_W), .EW(EW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_rdata(rsp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .home_idx(home_idx), .alt_idx(alt_idx), .want_tag(want_tag), .want_half(want_half),
    .home_ent(ent[0]), .alt_ent(ent[1]), .home_hit(hit[0]), .alt_hit(hit[1]),
    .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr0_ent(wr0_ent),
    .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_ent(wr1_ent)
  );
endmodule

// File: rtl/pac_cache_chk.sv
module pac_cache_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  AST_KIND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid == (rsp_kind != 2'b00)));                                    // R2
  AST_FAST_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'b01) |-> $past(cpu_ready && cpu_req));      // R2
  AST_ACCEPT_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready) |=> ((rsp_valid && rsp_kind == 2'b01) || !cpu_ready)); // R9
  AST_SLOW_NO_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'b10) |-> ($past(!cpu_ready) && !$past(mem_req))); // R3
  AST_MISS_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'b11) |-> $past(mem_req && mem_ack && !mem_we)); // R5
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R7
  AST_MEM_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);                                                // R9
endmodule

bind pac_cache pac_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/pac_cache_tb.sv
module pac_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int MEM_LAT = 3;
  localparam logic [1:0] K_FAST = 2'b01, K_SLOW = 2'b10, K_MISS = 2'b11;

  logic clk, rst_n;
  logic cpu_req, cpu_we, cpu_ready, rsp_valid, mem_req, mem_we, mem_ack;
  logic [ADDR_W-1:0] cpu_addr, mem_addr;
  logic [DATA_W-1:0] cpu_wdata, rsp_rdata, mem_wdata, mem_rdata;
  logic [1:0] rsp_kind;

  int checks = 0, fails = 0;
  logic [33:0] exp_q [$];
  string       tag_q [$];
  int          wb_q  [$];
  logic [DATA_W-1:0] mem_m [int];

  pac_cache #(.ADDR_W(ADDR_W), .IDX_W(4), .DATA_W(DATA_W)) u_dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] mem_init(input int a);
    return 32'hD000_0000 | DATA_W'(a);
  endfunction

  function automatic logic [DATA_W-1:0] mem_get(input int a);
    return mem_m.exists(a) ? mem_m[a] : mem_init(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: acknowledges MEM_LAT cycles after a request appears
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_req) begin
        repeat (MEM_LAT - 1) @(negedge clk);
        if (mem_we) begin
          mem_m[int'(mem_addr)] = mem_wdata;
          wb_q.push_back(int'(mem_addr));
        end else begin
          mem_rdata = mem_get(int'(mem_addr));
        end
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  // Monitor: pops expected response and compares
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected response", 64'(rsp_kind), 64'(0));
      end else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_kind == e[33:32], {t, " kind"}, 64'(rsp_kind), 64'(e[33:32]));
        chk(rsp_rdata == e[31:0], {t, " data"}, 64'(rsp_rdata), 64'(e[31:0]));
      end
    end
  end

  // Driver: pushes the expectation, drives one access, checks timing
  task automatic access(input bit we, input int a, input logic [DATA_W-1:0] wd,
                        input logic [1:0] k, input logic [DATA_W-1:0] d,
                        input string req);
    int n;
    exp_q.push_back({k, d});
    tag_q.push_back(req);
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = ADDR_W'(a); cpu_wdata = wd;
    @(posedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        cpu_req = 1'b0;
        if (k != K_FAST)
          chk(cpu_ready == 1'b0, "R9 ready low while busy", 64'(cpu_ready), 64'(0));
      end
    end while (!rsp_valid && n < 100);
    if (k == K_FAST) chk(n == 1, "R2 fast latency", 64'(n), 64'(1));
    if (k == K_SLOW) chk(n == 2, "R3 slow latency", 64'(n), 64'(2));
    if (k == K_MISS) chk(rsp_valid, "R5 miss completes", 64'(rsp_valid), 64'(1));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // Pair of sets 3 and 11; A,B,C,D share index 3; P has A's tag at index 11
    int A, B, C, D, P, E;
    A = 'h013; B = 'h023; C = 'h033; D = 'h043; P = 'h01B; E = 'h100;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ready == 1'b1, "R1 ready after reset", 64'(cpu_ready), 64'(1));
    chk(rsp_valid == 1'b0 && mem_req == 1'b0, "R1 idle after reset",
        64'({rsp_valid, mem_req}), 64'(0));

    access(0, A, 0, K_MISS, mem_init(A), "R1 R5 cold read A");
    access(0, A, 0, K_FAST, mem_init(A), "R2 read A home");
    access(1, A, 32'h1111_1111, K_FAST, 32'h1111_1111, "R8 write A hit");
    access(0, B, 0, K_MISS, mem_init(B), "R6 read B displaces A");
    chk(wb_q.size() == 0, "R7 no write-back of empty slot", 64'(wb_q.size()), 64'(0));
    access(0, A, 0, K_SLOW, 32'h1111_1111, "R3 R6 R8 A in partner slot");
    access(0, A, 0, K_FAST, 32'h1111_1111, "R4 A fast after swap");
    access(0, B, 0, K_SLOW, mem_init(B), "R4 B slow after swap");
    access(0, C, 0, K_MISS, mem_init(C), "R7 read C evicts dirty A");
    chk(wb_q.size() == 1, "R7 one write-back", 64'(wb_q.size()), 64'(1));
    if (wb_q.size() > 0)
      chk(wb_q[0] == A, "R7 write-back address", 64'(wb_q[0]), 64'(A));
    chk(mem_get(A) == 32'h1111_1111, "R7 write-back data", 64'(mem_get(A)),
        64'h1111_1111);
    access(0, A, 0, K_MISS, 32'h1111_1111, "R6 R7 A refetched");
    access(0, P, 0, K_MISS, mem_init(P), "R10 same tag other half misses");
    access(0, C, 0, K_FAST, mem_init(C), "R6 C moved to its home");
    access(1, D, 32'h2222_0000, K_MISS, 32'h2222_0000, "R8 write miss allocates");
    access(0, D, 0, K_FAST, 32'h2222_0000, "R8 read D after write miss");
    chk(wb_q.size() == 1, "R7 R8 clean evictions write nothing",
        64'(wb_q.size()), 64'(1));
    access(0, E, 0, K_MISS, mem_init(E), "R5 cold read index 0");
    access(1, E, 32'h3333_4444, K_FAST, 32'h3333_4444, "R8 write E");
    access(0, E, 0, K_FAST, 32'h3333_4444, "R2 R8 read E");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all responses seen", 64'(exp_q.size()), 64'(0));
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule